// File: doc/BRIEF.md
# Parallel NOR Boot Image Loader

This block is the master side of a boot path that pulls an image out of a 16-bit wide parallel NOR flash. Once reset is released it opens the flash in plain asynchronous mode. It walks the address upward one word at a time from a fixed start offset and inspects the leading header words. A header can name a burst-clock ratio, and it can ask for synchronous operation. When synchronous operation is requested, the loader programs the flash's read-configuration register with a two-cycle command write. The configuration value rides on the low sixteen address lines during that write. The loader then restarts the image from its first word as a clocked burst. Otherwise it restarts and streams the image asynchronously.

Image words leave the block as a simple valid/data stream in address order. The block raises `done` after a fixed word count. Two revision bits on the top address lines confine each image to one quarter of the flash. A header that never terminates triggers a single fallback attempt from revision 0. If that attempt also fails, the block stops with `error` set.

Top module: `nor_boot_loader`

## Requirements
- R1: While reset is held, chip enable, output enable, write enable and address-valid are all high and no word, done, error or fallback is reported. After release, reads are asynchronous with chip enable, output enable and address-valid low. The first address is START_ADDR within the selected region. Each read holds for ACC_CYC clocks, and the address then advances by one.
- R2: Header reads classify each word. 16'h3C96 requests synchronous mode. A word whose bits [15:8] equal 8'hC5 is a clock command. 16'hE0F0 ends the header. Synchronous mode is used only if the request word appears before the end word; a request word after the end word has no effect.
- R3: Without a synchronous request, the loader restarts at START_ADDR and streams IMAGE_WORDS words asynchronously, one every ACC_CYC clocks, in address order.
- R4: With a synchronous request, two write cycles follow. In each, chip enable and write enable are low and output enable is high. Both cycles carry RCR_VALUE on address bits [15:0]. The first carries 16'h0060 on the data bus and the second 16'h0003. The data bus is driven only while output enable is high.
- R5: Write enable rises while chip enable is still low, and address and write data are unchanged across that rise.
- R6: The synchronous restart holds address-valid low for exactly one clock at START_ADDR, with chip enable and output enable low. The first SYNC_LAT flash clock strobes after that carry no data. Each later strobe captures one image word in order.
- R7: Burst words arrive every 2^s clocks. Here s is taken from bits [1:0] of the last clock command seen in the header (0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). If no clock command is seen, s is INT_SEL.
- R8: After IMAGE_WORDS streamed words, done rises and stays high, and chip enable, output enable and write enable are all high, leaving the flash in the read mode that was used.
- R9: The two top address bits carry the revision captured on the first clock after reset release. Only the lower bits count.
- R10: If no end word appears within HDR_LIMIT header reads, the loader forces the revision to 00, raises fallback and rescans asynchronously. A second such failure raises error, deselects the flash and streams nothing.
- R11: An end word that arrives as the HDR_LIMIT-th header read ends the header normally and causes no fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rev_sel_i | input | 2 | Revision region to boot from |
| flash_dq_i | input | 16 | Data read from the flash |
| flash_addr_o | output | ADDR_W | Flash word address, revision bits on top |
| flash_dq_o | output | 16 | Command data driven to the flash |
| flash_dq_oe_o | output | 1 | Enable for the data bus drivers |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |
| flash_we_n_o | output | 1 | Write enable, active low |
| flash_adv_n_o | output | 1 | Address-valid, active low |
| flash_clk_o | output | 1 | Burst clock strobe, one high cycle per flash clock |
| word_valid_o | output | 1 | Image word valid |
| word_data_o | output | 16 | Image word |
| done_o | output | 1 | Image fully streamed |
| error_o | output | 1 | Load abandoned |
| fallback_o | output | 1 | Fallback to revision 00 taken |

## Verification
The header-limit test and the end-word test can apply to the same read. This happens when the terminating word sits exactly at the last permitted header position, so the block must let the end word win over the failure path in that cycle. The bench provokes this by placing the end word at position HDR_LIMIT−1 of the fallback region. It then requires that fallback stays at its first-pass level, that the synchronous write pair follows, and that every streamed word matches the scoreboard. A second collision, between a burst strobe and the last image word completing the count, is judged by the absence of any extra word after `done`.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_HDR,
        ST_ASTREAM,
        ST_WGAP,
        ST_WSET,
        ST_WPUL,
        ST_WHOLD,
        ST_ADV,
        ST_BURST,
        ST_DONE,
        ST_ERR
    } nbl_state_e;

    localparam logic [15:0] NBL_CMD_SETUP   = 16'h0060;
    localparam logic [15:0] NBL_CMD_CONFIRM = 16'h0003;
    localparam int          NBL_DIV_W       = 3;

endpackage

// File: rtl/nbl_hdr_decode.sv
module nbl_hdr_decode #(
    parameter logic [15:0] SYNC_WORD = 16'h3C96,
    parameter logic [15:0] END_WORD  = 16'hE0F0,
    parameter logic [7:0]  CLK_TAG   = 8'hC5
) (
    input  logic [15:0] word_i,
    output logic        is_sync_o,
    output logic        is_end_o,
    output logic        is_clk_o,
    output logic [1:0]  sel_o
);
    always_comb begin
        is_sync_o = (word_i == SYNC_WORD);
        is_end_o  = (word_i == END_WORD);
        is_clk_o  = (word_i[15:8] == CLK_TAG);
        sel_o     = word_i[1:0];
    end
endmodule

// File: rtl/nbl_burst_strobe.sv
module nbl_burst_strobe
    import nbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] ratio_sel_i,
    output logic       tick_o
);
    logic [NBL_DIV_W-1:0] cnt_d, cnt_q, mask;

    always_comb begin
        mask   = NBL_DIV_W'((4'd1 << ratio_sel_i) - 4'd1);
        cnt_d  = run_i ? ((cnt_q + NBL_DIV_W'(1)) & mask) : '0;
        tick_o = run_i && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nbl_addr_gen.sv
module nbl_addr_gen #(
    parameter int ADDR_W     = 26,
    parameter int REV_EN     = 1,
    parameter int START_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [1:0]        rev_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int LOW_W = (REV_EN != 0) ? ADDR_W - 2 : ADDR_W;

    logic [LOW_W-1:0] low_d, low_q;

    always_comb begin
        if (load_i)      low_d = LOW_W'(START_ADDR);
        else if (step_i) low_d = low_q + LOW_W'(1);
        else             low_d = low_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= LOW_W'(START_ADDR);
        else        low_q <= low_d;
    end

    generate
        if (REV_EN != 0) begin : g_rev
            logic [1:0] rev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      rev_q <= 2'b00;
                else if (load_i) rev_q <= rev_i;
            end
            assign addr_o = {rev_q, low_q};
        end else begin : g_flat
            logic [1:0] unused_rev;
            assign unused_rev = rev_i;
            assign addr_o     = low_q;
        end
    endgenerate
endmodule

// File: rtl/nor_boot_loader.sv
module nor_boot_loader
    import nbl_pkg::*;
#(
    parameter int          ADDR_W      = 26,
    parameter bit          REV_EN      = 1'b1,
    parameter int          START_ADDR  = 0,
    parameter int          ACC_CYC     = 4,
    parameter int          WE_PULSE    = 3,
    parameter int          SYNC_LAT    = 5,
    parameter logic [15:0] RCR_VALUE   = 16'h1B47,
    parameter int          IMAGE_WORDS = 1048576,
    parameter int          HDR_LIMIT   = 64,
    parameter logic [1:0]  INT_SEL     = 2'd3,
    parameter logic [15:0] SYNC_WORD   = 16'h3C96,
    parameter logic [15:0] END_WORD    = 16'hE0F0,
    parameter logic [7:0]  CLK_TAG     = 8'hC5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rev_sel_i,
    input  logic [15:0]       flash_dq_i,
    output logic [ADDR_W-1:0] flash_addr_o,
    output logic [15:0]       flash_dq_o,
    output logic              flash_dq_oe_o,
    output logic              flash_ce_n_o,
    output logic              flash_oe_n_o,
    output logic              flash_we_n_o,
    output logic              flash_adv_n_o,
    output logic              flash_clk_o,
    output logic              word_valid_o,
    output logic [15:0]       word_data_o,
    output logic              done_o,
    output logic              error_o,
    output logic              fallback_o
);
    localparam int CNT_MAX = (ACC_CYC > WE_PULSE) ? ACC_CYC : WE_PULSE;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int HDR_W   = $clog2(HDR_LIMIT + 1);
    localparam int WORD_W  = $clog2(IMAGE_WORDS + 1);
    localparam int LAT_W   = $clog2(SYNC_LAT + 1);

    typedef struct packed {
        nbl_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [HDR_W-1:0] hdr;
        logic [WORD_W-1:0] words;
        logic [LAT_W-1:0] lat;
        logic [1:0]       wr_idx;
        logic             sync_seen;
        logic [1:0]       sel;
        logic [1:0]       rev;
        logic             fb;
        logic             vld;
        logic [15:0]      data;
    } ctl_t;

    ctl_t d, q;

    logic              addr_load, addr_step;
    logic [ADDR_W-1:0] addr_raw;
    logic              tick;
    logic              dec_sync, dec_end, dec_clk;
    logic [1:0]        dec_sel;

    nbl_hdr_decode #(
        .SYNC_WORD (SYNC_WORD),
        .END_WORD  (END_WORD),
        .CLK_TAG   (CLK_TAG)
    ) u_dec (
        .word_i    (flash_dq_i),
        .is_sync_o (dec_sync),
        .is_end_o  (dec_end),
        .is_clk_o  (dec_clk),
        .sel_o     (dec_sel)
    );

    nbl_addr_gen #(
        .ADDR_W     (ADDR_W),
        .REV_EN     (REV_EN ? 1 : 0),
        .START_ADDR (START_ADDR)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (addr_load),
        .step_i (addr_step),
        .rev_i  (d.rev),
        .addr_o (addr_raw)
    );

    nbl_burst_strobe u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (q.st == ST_BURST),
        .ratio_sel_i (q.sel),
        .tick_o      (tick)
    );

    // next-state computation
    always_comb begin
        d         = q;
        d.vld     = 1'b0;
        addr_load = 1'b0;
        addr_step = 1'b0;
        case (q.st)
            ST_BOOT: begin
                d.rev     = REV_EN ? rev_sel_i : 2'b00;
                d.cnt     = '0;
                addr_load = 1'b1;
                d.st      = ST_HDR;
            end
            ST_HDR: begin
                if (q.cnt == CNT_W'(ACC_CYC - 1)) begin
                    d.cnt     = '0;
                    addr_step = 1'b1;
                    d.hdr     = q.hdr + HDR_W'(1);
                    if (dec_sync) d.sync_seen = 1'b1;
                    if (dec_clk)  d.sel = dec_sel;
                    if (dec_end) begin
                        if (q.sync_seen) begin
                            d.wr_idx = 2'd0;
                            d.st     = ST_WGAP;
                        end else begin
                            addr_load = 1'b1;
                            d.st      = ST_ASTREAM;
                        end
                    end else if (q.hdr == HDR_W'(HDR_LIMIT - 1)) begin
                        if (REV_EN && !q.fb) begin
                            d.fb        = 1'b1;
                            d.rev       = 2'b00;
                            d.hdr       = '0;
                            d.sync_seen = 1'b0;
                            d.sel       = INT_SEL;
                            addr_load   = 1'b1;
                            d.st        = ST_HDR;
                        end else begin
                            d.st = ST_ERR;
                        end
                    end
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_ASTREAM: begin
                if (q.cnt == CNT_W'(ACC_CYC - 1)) begin
                    d.cnt     = '0;
                    addr_step = 1'b1;
                    d.vld     = 1'b1;
                    d.data    = flash_dq_i;
                    d.words   = q.words + WORD_W'(1);
                    if (q.words == WORD_W'(IMAGE_WORDS - 1)) d.st = ST_DONE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_WGAP: begin
                if (q.wr_idx == 2'd2) begin
                    addr_load = 1'b1;
                    d.st      = ST_ADV;
                end else begin
                    d.st = ST_WSET;
                end
            end
            ST_WSET: begin
                d.cnt = '0;
                d.st  = ST_WPUL;
            end
            ST_WPUL: begin
                if (q.cnt == CNT_W'(WE_PULSE - 1)) begin
                    d.cnt = '0;
                    d.st  = ST_WHOLD;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_WHOLD: begin
                d.wr_idx = q.wr_idx + 2'd1;
                d.st     = ST_WGAP;
            end
            ST_ADV: begin
                d.lat = '0;
                d.st  = ST_BURST;
            end
            ST_BURST: begin
                if (tick) begin
                    if (q.lat < LAT_W'(SYNC_LAT)) begin
                        d.lat = q.lat + LAT_W'(1);
                    end else begin
                        d.vld   = 1'b1;
                        d.data  = flash_dq_i;
                        d.words = q.words + WORD_W'(1);
                        if (q.words == WORD_W'(IMAGE_WORDS - 1)) d.st = ST_DONE;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_BOOT;
            q.sel <= INT_SEL;
        end else begin
            q <= d;
        end
    end

    // flash-side pin decode
    always_comb begin
        flash_ce_n_o  = 1'b1;
        flash_oe_n_o  = 1'b1;
        flash_we_n_o  = 1'b1;
        flash_adv_n_o = 1'b1;
        flash_dq_oe_o = 1'b0;
        flash_dq_o    = 16'h0000;
        flash_addr_o  = addr_raw;
        case (q.st)
            ST_HDR, ST_ASTREAM, ST_ADV: begin
                flash_ce_n_o  = 1'b0;
                flash_oe_n_o  = 1'b0;
                flash_adv_n_o = 1'b0;
            end
            ST_WSET, ST_WPUL, ST_WHOLD: begin
                flash_ce_n_o  = 1'b0;
                flash_we_n_o  = (q.st != ST_WPUL);
                flash_dq_oe_o = 1'b1;
                flash_dq_o    = (q.wr_idx == 2'd0) ? NBL_CMD_SETUP : NBL_CMD_CONFIRM;
                flash_addr_o  = {addr_raw[ADDR_W-1:16], RCR_VALUE};
            end
            ST_BURST: begin
                flash_ce_n_o = 1'b0;
                flash_oe_n_o = 1'b0;
            end
            default: ;
        endcase
    end

    assign flash_clk_o  = tick;
    assign word_valid_o = q.vld;
    assign word_data_o  = q.data;
    assign done_o       = (q.st == ST_DONE);
    assign error_o      = (q.st == ST_ERR);
    assign fallback_o   = q.fb;

endmodule

// File: rtl/nbl_checker.sv
module nbl_checker #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] flash_addr_o,
    input logic [15:0]       flash_dq_o,
    input logic              flash_dq_oe_o,
    input logic              flash_ce_n_o,
    input logic              flash_oe_n_o,
    input logic              flash_we_n_o,
    input logic              flash_adv_n_o,
    input logic              flash_clk_o,
    input logic              word_valid_o,
    input logic              done_o,
    input logic              error_o
);
    assert_write_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n_o |-> (!flash_ce_n_o && flash_oe_n_o && flash_dq_oe_o));

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flash_dq_oe_o |-> flash_oe_n_o);

    assert_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n_o) |-> (!flash_ce_n_o && $stable(flash_addr_o) && $stable(flash_dq_o)));

    assert_strobe_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flash_clk_o |-> (!flash_ce_n_o && !flash_oe_n_o && flash_adv_n_o));

    assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flash_ce_n_o && flash_oe_n_o && flash_we_n_o));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    assert_error_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (flash_ce_n_o && !word_valid_o && !done_o));
endmodule

bind nor_boot_loader nbl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flash_addr_o  (flash_addr_o),
    .flash_dq_o    (flash_dq_o),
    .flash_dq_oe_o (flash_dq_oe_o),
    .flash_ce_n_o  (flash_ce_n_o),
    .flash_oe_n_o  (flash_oe_n_o),
    .flash_we_n_o  (flash_we_n_o),
    .flash_adv_n_o (flash_adv_n_o),
    .flash_clk_o   (flash_clk_o),
    .word_valid_o  (word_valid_o),
    .done_o        (done_o),
    .error_o       (error_o)
);

// File: tb/nor_boot_loader_tb.sv
module nor_boot_loader_tb;
    localparam int          AW     = 18;
    localparam int          START  = 4;
    localparam int          ACC    = 3;
    localparam int          WEP    = 2;
    localparam int          LAT    = 3;
    localparam logic [15:0] RCR    = 16'h2A5D;
    localparam int          IMG    = 20;
    localparam int          HLIM   = 6;
    localparam logic [1:0]  ISEL   = 2'd2;
    localparam logic [15:0] W_SYNC = 16'h3C96;
    localparam logic [15:0] W_END  = 16'hE0F0;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [1:0]    rev_sel = 2'd0;
    logic [15:0]   flash_dq_i;
    logic [AW-1:0] addr;
    logic [15:0]   dq_o;
    logic          dq_oe, ce_n, oe_n, we_n, adv_n, fclk;
    logic          vld, done, err, fb;
    logic [15:0]   wdata;

    nor_boot_loader #(
        .ADDR_W(AW), .REV_EN(1'b1), .START_ADDR(START), .ACC_CYC(ACC),
        .WE_PULSE(WEP), .SYNC_LAT(LAT), .RCR_VALUE(RCR), .IMAGE_WORDS(IMG),
        .HDR_LIMIT(HLIM), .INT_SEL(ISEL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rev_sel_i(rev_sel), .flash_dq_i(flash_dq_i),
        .flash_addr_o(addr), .flash_dq_o(dq_o), .flash_dq_oe_o(dq_oe),
        .flash_ce_n_o(ce_n), .flash_oe_n_o(oe_n), .flash_we_n_o(we_n),
        .flash_adv_n_o(adv_n), .flash_clk_o(fclk), .word_valid_o(vld),
        .word_data_o(wdata), .done_o(done), .error_o(err), .fallback_o(fb)
    );

    int total = 0;
    int failed = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model
    logic [15:0] mem [0:255];
    logic        sync_mode;
    logic [1:0]  b_rev;
    logic [5:0]  b_off;
    int          pcnt;

    always_comb begin
        logic [5:0] off;
        off = b_off + 6'(pcnt - LAT);
        if (sync_mode)
            flash_dq_i = (pcnt >= LAT) ? mem[{b_rev, off}] : 16'hBAD0;
        else if (!ce_n && !oe_n)
            flash_dq_i = mem[{addr[17:16], addr[5:0]}];
        else
            flash_dq_i = 16'hDEAD;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= 0;
        end else if (sync_mode && !ce_n && !adv_n) begin
            b_rev <= addr[17:16];
            b_off <= addr[5:0];
            pcnt  <= 0;
        end else if (sync_mode && !ce_n && fclk) begin
            pcnt <= pcnt + 1;
        end
    end

    // scoreboard and monitors
    logic [15:0] exp_q[$];
    string       cur_tag = "R3";
    int          exp_period = ACC;
    logic [15:0] wr_a [0:3];
    logic [15:0] wr_d [0:3];
    int          wr_n;
    logic        we_prev;
    int          cyc = 0;
    int          last_cyc;
    int          per_bad, region_bad;
    logic [AW-1:0] first_addr;
    bit          first_seen;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            sync_mode  = 1'b0;
            wr_n       = 0;
            we_prev    = 1'b1;
            last_cyc   = -1;
            per_bad    = 0;
            region_bad = 0;
            first_seen = 1'b0;
        end else begin
            if (!we_prev && we_n && !ce_n && wr_n < 4) begin
                wr_a[wr_n] = addr[15:0];
                wr_d[wr_n] = dq_o;
                wr_n++;
                if (wr_n == 2 && wr_a[0] == RCR && wr_d[0] == 16'h0060 &&
                    wr_a[1] == RCR && wr_d[1] == 16'h0003)
                    sync_mode = 1'b1;
            end
            we_prev = we_n;
            if (!ce_n && !oe_n && !adv_n) begin
                if (!first_seen) begin
                    first_addr = addr;
                    first_seen = 1'b1;
                end
                if (addr[17:16] != (fb ? 2'd0 : rev_sel)) region_bad++;
            end
            if (vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " extra word"}, wdata, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(wdata == e, cur_tag, wdata, e);
                end
                if (last_cyc >= 0 && (cyc - last_cyc) != exp_period) per_bad++;
                last_cyc = cyc;
            end
        end
    end

    function automatic logic [15:0] filler(input int r, input int o);
        return 16'h1000 | 16'(r << 8) | 16'(o);
    endfunction

    task automatic fill_all();
        for (int r = 0; r < 4; r++)
            for (int o = 0; o < 64; o++)
                mem[r*64 + o] = filler(r, o);
    endtask

    task automatic put(input int r, input int pos, input logic [15:0] w);
        mem[r*64 + START + pos] = w;
    endtask

    task automatic run_load(input logic [1:0] rev, input int exp_rev, input int period,
                            input bit exp_sync, input bit exp_fb, input bit exp_err,
                            input string tag, input string ptag);
        rst_n = 1'b0;
        rev_sel = rev;
        exp_q.delete();
        cur_tag = tag;
        exp_period = period;
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n && we_n && adv_n, "R1 reset pins", {ce_n, oe_n, we_n, adv_n}, 4'hF);
        chk(!vld && !done && !err && !fb, "R1 reset flags", {vld, done, err, fb}, 0);
        if (!exp_err)
            for (int k = 0; k < IMG; k++) exp_q.push_back(mem[exp_rev*64 + START + k]);
        rst_n = 1'b1;
        for (int t = 0; t < 8000 && !done && !err; t++) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(first_addr == {rev, 16'(START)}, "R1 first address", first_addr, {rev, 16'(START)});
        chk(done == !exp_err, "R8 done", done, !exp_err);
        chk(err == exp_err, "R10 error", err, exp_err);
        chk(fb == exp_fb, "R10 fallback", fb, exp_fb);
        chk(exp_q.size() == 0, {tag, " words missing"}, exp_q.size(), 0);
        chk(per_bad == 0, {ptag, " word period"}, per_bad, 0);
        chk(region_bad == 0, "R9 revision bits", region_bad, 0);
        chk(ce_n && oe_n && we_n, "R8 idle pins", {ce_n, oe_n, we_n}, 3'h7);
        if (exp_sync) begin
            chk(wr_n == 2, "R4 write count", wr_n, 2);
            chk(wr_a[0] == RCR && wr_a[1] == RCR, "R4 address value", wr_a[1], RCR);
            chk(wr_d[0] == 16'h0060, "R4 first command", wr_d[0], 16'h0060);
            chk(wr_d[1] == 16'h0003, "R5 second command at rise", wr_d[1], 16'h0003);
        end else begin
            chk(wr_n == 0, "R2 no write", wr_n, 0);
        end
    endtask

    initial begin
        // sync with clock command ratio 2
        fill_all();
        put(2, 0, 16'hC501); put(2, 1, W_SYNC); put(2, 2, W_END);
        run_load(2'd2, 2, 2, 1, 0, 0, "R6", "R7");
        // async only
        fill_all();
        put(1, 0, W_END);
        run_load(2'd1, 1, ACC, 0, 0, 0, "R3", "R3");
        // fallback, end word on the last permitted read
        fill_all();
        put(0, 0, W_SYNC); put(0, HLIM - 1, W_END);
        run_load(2'd3, 0, 1 << ISEL, 1, 1, 0, "R11", "R7");
        // fallback also fails
        fill_all();
        run_load(2'd0, 0, ACC, 0, 1, 1, "R10", "R10");
        // sync word first, ratio 1
        fill_all();
        put(1, 0, W_SYNC); put(1, 1, 16'hC500); put(1, 2, W_END);
        run_load(2'd1, 1, 1, 1, 0, 0, "R6", "R7");
        // sync word after end is ignored
        fill_all();
        put(2, 0, W_END); put(2, 1, W_SYNC);
        run_load(2'd2, 2, ACC, 0, 0, 0, "R2", "R3");
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule